// File: doc/BRIEF.md
# Settable 24-hour BCD time-of-day core

This block keeps the time of day as three packed-BCD counters: seconds, minutes and hours. A one-cycle pulse on `secTick`, arriving once per second, advances the count. A seconds wrap carries into minutes, and a minutes wrap carries into hours, so the core runs through a full 24-hour cycle. Every register runs on the single system clock. Ticks and set controls only act as enables.

Two active-low set controls let a user adjust the clock by hand. While one of them is held low, its stage takes the tick itself in place of the carry from the stage below, so it moves on once per tick. An active-low clear returns the whole core to midnight. The core also raises a one-cycle chime flag at each exact hour and gives a seven-segment pattern for each of the six digits. Multiplexing those patterns onto a physical display is left to the surrounding logic.

Top module: `clock_core`

## Requirements
- R1: Each time output is a 7-bit packed-BCD word with the tens digit in bits 6..4 and the units digit in bits 3..0. Each tick moves the seconds on by one, and a units digit of 9 rolls to 0 with the tens digit incremented. All results appear on the clock edge at which `secTick` is sampled high.
- R2: Seconds step from 59 to 00 and, on the same edge, move the minutes on by one.
- R3: Minutes step from 59 to 00 and, on the same edge, move the hours on by one.
- R4: Hours step from 23 to 00, and the hours never leave the range 00..23.
- R5: On an edge where `secTick` is low, all three counters keep their values and `chime` is low.
- R6: An edge with `clearN` low sets all three counters to 00 and `chime` to 0, whatever the tick and set inputs are.
- R7: While `minSetN` is low, each tick moves the minutes on by exactly one and the seconds keep counting. A seconds wrap in that cycle adds no second step. A minutes wrap from 59 to 00 still moves the hours on.
- R8: While `hourSetN` is low, each tick moves the hours on by exactly one, and a minutes wrap in that cycle adds no second step.
- R9: `chime` is high for exactly the one cycle after a tick edge that leaves minutes and seconds both at 00. It is low in every other cycle.
- R10: `segOut` holds six 7-bit active-high patterns, segment a in bit 6 down to segment g in bit 0. Slot k occupies bits 7k+6..7k, in the order seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens. Digits 0..9 map to 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111 and 1111011.
- R11: A digit code above the legal maximum for its position gives the blank pattern 0000000. The maximum is 9 for a units digit, 5 for a seconds or minutes tens digit and 2 for an hours tens digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| secTick | input | 1 | One-cycle pulse per second, acts as the count enable |
| clearN | input | 1 | Active-low synchronous clear to 00:00:00 |
| minSetN | input | 1 | Active-low: minutes advance on every tick |
| hourSetN | input | 1 | Active-low: hours advance on every tick |
| secBcd | output | 7 | Seconds, packed BCD |
| minBcd | output | 7 | Minutes, packed BCD |
| hourBcd | output | 7 | Hours, packed BCD |
| chime | output | 1 | One-cycle flag at each exact hour |
| segOut | output | 42 | Six seven-segment patterns, seconds units in the low slot |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a seconds wrap and a manual set. The bench holds `minSetN` or `hourSetN` low through several wraps from 59 and judges each edge against a model that counts exactly one step per stage. The second pair is clear and tick: the bench holds `clearN` low together with a tick and both set controls. It then expects 00:00:00 with the chime low, even though a normal tick in that cycle would have advanced the time.

// File: rtl/clock_pkg.sv
package clock_pkg;
  localparam int UNIT_W = 4;
  localparam int TENS_W = 3;
  localparam int WORD_W = TENS_W + UNIT_W;
  localparam int SEG_W = 7;
  localparam int STAGES = 3;
  localparam int DIGITS = 2 * STAGES;

  // terminal value per stage: index 0 seconds, 1 minutes, 2 hours
  localparam int LAST_TENS [STAGES] = '{5, 5, 2};
  localparam int LAST_UNITS [STAGES] = '{9, 9, 3};

  typedef logic [WORD_W-1:0] bcdWord_t;

  typedef struct packed {
    logic clear;
    logic secInc;
    logic minInc;
    logic hourInc;
  } clkStrobe_t;
endpackage

// File: rtl/bcd_next.sv
module bcd_next
  import clock_pkg::*;
#(
  parameter int TENS_LAST = 5,
  parameter int UNITS_LAST = 9
) (
  input  bcdWord_t curWord,
  input  logic     clear,
  input  logic     inc,
  output bcdWord_t nextWord
);
  localparam logic [TENS_W-1:0] TensMax = TENS_W'(TENS_LAST);
  localparam bcdWord_t LastWord = bcdWord_t'((TENS_LAST << UNIT_W) + UNITS_LAST);
  localparam logic [UNIT_W-1:0] UnitNine = UNIT_W'(9);

  logic [UNIT_W-1:0] units;
  logic [TENS_W-1:0] tens;
  logic legal;

  assign units = curWord[UNIT_W-1:0];
  assign tens = curWord[WORD_W-1:UNIT_W];
  assign legal = (units <= UnitNine) && (tens <= TensMax) && (curWord <= LastWord);

  always_comb begin
    nextWord = curWord;
    if (clear) begin
      nextWord = '0;
    end else if (inc) begin
      if (!legal || curWord == LastWord) begin
        nextWord = '0;
      end else if (units == UnitNine) begin
        nextWord = curWord + bcdWord_t'(7);
      end else begin
        nextWord = curWord + bcdWord_t'(1);
      end
    end
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import clock_pkg::*;
#(
  parameter int MAX_DIGIT = 9
) (
  input  logic [UNIT_W-1:0] digit,
  output logic [SEG_W-1:0]  seg
);
  localparam logic [UNIT_W-1:0] DigitMax = UNIT_W'(MAX_DIGIT);

  always_comb begin
    seg = '0;
    if (digit <= DigitMax) begin
      case (digit)
        4'd0: seg = 7'b1111110;
        4'd1: seg = 7'b0110000;
        4'd2: seg = 7'b1101101;
        4'd3: seg = 7'b1111001;
        4'd4: seg = 7'b0110011;
        4'd5: seg = 7'b1011011;
        4'd6: seg = 7'b1011111;
        4'd7: seg = 7'b1110000;
        4'd8: seg = 7'b1111111;
        4'd9: seg = 7'b1111011;
        default: seg = '0;
      endcase
    end
  end
endmodule

// File: rtl/clock_ctrl.sv
module clock_ctrl
  import clock_pkg::*;
(
  input  logic       secTick,
  input  logic       clearN,
  input  logic       minSetN,
  input  logic       hourSetN,
  input  logic [1:0] atEnd,
  output clkStrobe_t strobe
);
  logic secCarry;
  logic minCarry;

  always_comb begin
    secCarry = secTick && atEnd[0];
    strobe.clear = !clearN;
    strobe.secInc = secTick;
    strobe.minInc = minSetN ? secCarry : secTick;
    minCarry = strobe.minInc && atEnd[1];
    strobe.hourInc = hourSetN ? minCarry : secTick;
  end
endmodule

// File: rtl/clock_datapath.sv
module clock_datapath
  import clock_pkg::*;
(
  input  logic                     clk,
  input  clkStrobe_t               strobe,
  output logic [STAGES-1:0][WORD_W-1:0] words,
  output logic [1:0]               atEnd,
  output logic                     chime
);
  logic [STAGES-1:0] incVec;
  logic [STAGES-1:0][WORD_W-1:0] nextWords;

  assign incVec = {strobe.hourInc, strobe.minInc, strobe.secInc};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    bcd_next #(
      .TENS_LAST (LAST_TENS[i]),
      .UNITS_LAST(LAST_UNITS[i])
    ) u_next (
      .curWord (words[i]),
      .clear   (strobe.clear),
      .inc     (incVec[i]),
      .nextWord(nextWords[i])
    );

    if (i < 2) begin : g_end
      assign atEnd[i] = (words[i] == bcdWord_t'((LAST_TENS[i] << UNIT_W) + LAST_UNITS[i]));
    end
  end

  always_ff @(posedge clk) begin
    words <= nextWords;
    chime <= !strobe.clear && strobe.secInc && (nextWords[0] == '0) && (nextWords[1] == '0);
  end
endmodule

// File: rtl/clock_core.sv
module clock_core
  import clock_pkg::*;
(
  input  logic        clk,
  input  logic        secTick,
  input  logic        clearN,
  input  logic        minSetN,
  input  logic        hourSetN,
  output logic [6:0]  secBcd,
  output logic [6:0]  minBcd,
  output logic [6:0]  hourBcd,
  output logic        chime,
  output logic [41:0] segOut
);
  clkStrobe_t strobe;
  logic [STAGES-1:0][WORD_W-1:0] words;
  logic [1:0] atEnd;

  clock_ctrl u_ctrl (
    .secTick (secTick),
    .clearN  (clearN),
    .minSetN (minSetN),
    .hourSetN(hourSetN),
    .atEnd   (atEnd),
    .strobe  (strobe)
  );

  clock_datapath u_dp (
    .clk   (clk),
    .strobe(strobe),
    .words (words),
    .atEnd (atEnd),
    .chime (chime)
  );

  assign secBcd = words[0];
  assign minBcd = words[1];
  assign hourBcd = words[2];

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    localparam int MaxD = (k % 2 == 0) ? 9 : LAST_TENS[k / 2];
    logic [UNIT_W-1:0] digit;
    if (k % 2 == 0) begin : g_lo
      assign digit = words[k / 2][UNIT_W-1:0];
    end else begin : g_hi
      assign digit = {1'b0, words[k / 2][WORD_W-1:UNIT_W]};
    end
    seg_decoder #(.MAX_DIGIT(MaxD)) u_seg (
      .digit(digit),
      .seg  (segOut[k*SEG_W +: SEG_W])
    );
  end
endmodule

// File: rtl/clock_core_checker.sv
module clock_core_checker (
  input logic        clk,
  input logic        secTick,
  input logic        clearN,
  input logic        minSetN,
  input logic        hourSetN,
  input logic [6:0]  secBcd,
  input logic [6:0]  minBcd,
  input logic [6:0]  hourBcd,
  input logic        chime,
  input logic [41:0] segOut
);
  assert_clear_R6: assert property (@(posedge clk)
    !clearN |=> (secBcd == 7'h00 && minBcd == 7'h00 && hourBcd == 7'h00 && !chime));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clearN)
    !secTick |=> ($stable(secBcd) && $stable(minBcd) && $stable(hourBcd) && !chime));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!clearN)
    (secTick && secBcd == 7'h59) |=> secBcd == 7'h00);

  assert_hour_range_R4: assert property (@(posedge clk) disable iff (!clearN)
    hourBcd <= 7'h23 && hourBcd[3:0] <= 4'd9);

  assert_hour_set_wrap_R8: assert property (@(posedge clk) disable iff (!clearN)
    (secTick && !hourSetN && hourBcd == 7'h23) |=> hourBcd == 7'h00);

  assert_min_set_wrap_R7: assert property (@(posedge clk) disable iff (!clearN)
    (secTick && !minSetN && minBcd == 7'h59) |=> minBcd == 7'h00);

  assert_chime_at_hour_R9: assert property (@(posedge clk) disable iff (!clearN)
    chime |-> (secBcd == 7'h00 && minBcd == 7'h00));

  assert_chime_pulse_R9: assert property (@(posedge clk) disable iff (!clearN)
    chime |=> !chime);

  assert_seg_zero_R10: assert property (@(posedge clk) disable iff (!clearN)
    (secBcd == 7'h00) |-> segOut[6:0] == 7'b1111110);
endmodule

bind clock_core clock_core_checker u_chk (.*);

// File: tb/tb_clock_core.sv
module tb_clock_core;
  logic clk = 1'b0;
  logic secTick = 1'b0;
  logic clearN = 1'b0;
  logic minSetN = 1'b1;
  logic hourSetN = 1'b1;
  logic [6:0] secBcd, minBcd, hourBcd;
  logic chime;
  logic [41:0] segOut;

  logic [3:0] dIn = 4'd0;
  logic [6:0] segU, segT, segH;

  int runCount = 0;
  int failCount = 0;
  int cycles = 0;
  int s = 0, m = 0, h = 0;
  logic chExp = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clock_core dut (
    .clk(clk), .secTick(secTick), .clearN(clearN), .minSetN(minSetN),
    .hourSetN(hourSetN), .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd),
    .chime(chime), .segOut(segOut)
  );

  seg_decoder #(.MAX_DIGIT(9)) decUnits (.digit(dIn), .seg(segU));
  seg_decoder #(.MAX_DIGIT(5)) decTens (.digit(dIn), .seg(segT));
  seg_decoder #(.MAX_DIGIT(2)) decHour (.digit(dIn), .seg(segH));

  function automatic logic [6:0] bcd(input int v);
    return 7'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic logic [6:0] segOf(input int d);
    case (d)
      0: return 7'b1111110;
      1: return 7'b0110000;
      2: return 7'b1101101;
      3: return 7'b1111001;
      4: return 7'b0110011;
      5: return 7'b1011011;
      6: return 7'b1011111;
      7: return 7'b1110000;
      8: return 7'b1111111;
      9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [41:0] expSegs();
    return {segOf(h / 10), segOf(h % 10), segOf(m / 10), segOf(m % 10),
            segOf(s / 10), segOf(s % 10)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic c, input logic ms, input logic hs,
                      input string tag);
    logic mi, hi;
    secTick = t; clearN = c; minSetN = ms; hourSetN = hs;
    @(posedge clk);
    if (!c) begin
      s = 0; m = 0; h = 0; chExp = 1'b0;
    end else if (t) begin
      mi = ms ? (s == 59) : 1'b1;
      hi = hs ? (mi && m == 59) : 1'b1;
      s = (s + 1) % 60;
      if (mi) m = (m + 1) % 60;
      if (hi) h = (h + 1) % 24;
      chExp = (s == 0 && m == 0);
    end else begin
      chExp = 1'b0;
    end
    @(negedge clk);
    check(tag, {secBcd, minBcd, hourBcd}, {bcd(s), bcd(m), bcd(h)});
    check("R9", chime, chExp);
    check("R10", segOut, expSegs());
  endtask

  function automatic string dayTag();
    if (s == 59 && m == 59 && h == 23) return "R4";
    if (s == 59 && m == 59) return "R3";
    if (s == 59) return "R2";
    return "R1";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 120000 && !done) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected<=120000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R6 reset state, clear overrides tick and both set controls
    step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    // full day, one tick per cycle: R1 R2 R3 R4
    for (int i = 0; i < 86400; i++) step(1'b1, 1'b1, 1'b1, 1'b1, dayTag());
    // R5 idle edges hold the time
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R5");
    // R7 manual minutes, ticks every other cycle, through seconds and minutes wraps
    for (int i = 0; i < 130; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b1, "R7");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R5");
    end
    // R8 manual hours, including a wrap from 23 and a seconds wrap
    for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    // both set controls held
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
    // R6 clear in the middle of the run with a tick
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R1");
    secTick = 1'b0;
    // R10 R11 decoder sweep per digit position
    for (int d = 0; d < 16; d++) begin
      dIn = 4'(d);
      #1;
      check(d <= 9 ? "R10" : "R11", segU, d <= 9 ? segOf(d) : 7'b0);
      check(d <= 5 ? "R10" : "R11", segT, d <= 5 ? segOf(d) : 7'b0);
      check(d <= 2 ? "R10" : "R11", segH, d <= 2 ? segOf(d) : 7'b0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule